// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the byte-level responder for a 256-byte serial memory on a two-wire bus. A separate condition detector turns the raw bus into single-cycle events: START, STOP, clock rising edge (with the sampled data line) and clock falling edge. The engine consumes these events. It shifts in the control byte, the word address and write data. It acknowledges by asking the pad to pull the data line low, and it shifts read data out the same way.

The engine keeps one address pointer for reads and writes alike. Write bytes go to a page buffer as an address/data strobe. A commit pulse on STOP tells the write engine to program them. While the write engine reports busy, the engine gives no acknowledge of any kind. Read data comes from a synchronous memory read port addressed by the pointer.

Top module: `serial_mem_slave`

## Requirements
- R1: A control byte whose upper four bits (first four sent) are 1010 is acknowledged. The next three bits are ignored, and the last bit selects read (1) or write (0). The acknowledge holds the data line low through the whole ninth clock high period.
- R2: A control byte with any other upper nibble is not acknowledged. After it, the engine drives nothing and accepts nothing until the next START.
- R3: While the busy input is high, no acknowledge is given, so every control byte goes unanswered.
- R4: In a write, the byte after the control byte loads the pointer. Each later byte is acknowledged and presented once on the page-buffer strobe with the current pointer as its address. The pointer then advances by one.
- R5: A STOP after at least one accepted data byte gives a one-cycle commit pulse. A START or STOP with no accepted data byte since the last START gives none.
- R6: A repeated START right after the word address programs nothing but keeps the loaded pointer. A following read returns the byte at that address.
- R7: A read that does not first set an address returns the byte at one past the last byte accessed.
- R8: Read bytes go out most significant bit first. The data line changes only after clock falling edges. The line is released during the master's acknowledge slot.
- R9: When the master acknowledges a byte, the next byte is sent. The pointer wraps from 255 to 0.
- R10: When the master does not acknowledge, the line stays released and further clocks are ignored until the next START or STOP.
- R11: A START or STOP in the middle of a byte abandons that byte and releases the line. A START then waits for a new control byte. A partly received data byte is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | START (or repeated START) seen, one cycle |
| ev_stop | input | 1 | STOP seen, one cycle |
| ev_rise | input | 1 | Bus clock rising edge, one cycle |
| ev_fall | input | 1 | Bus clock falling edge, one cycle |
| sda_in | input | 1 | Data line level, valid at ev_rise |
| wr_busy | input | 1 | Write engine is programming |
| sda_pull | output | 1 | Pull the data line low |
| mem_addr | output | 8 | Memory read address (the pointer) |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_addr |
| pb_we | output | 1 | Page-buffer write strobe |
| pb_addr | output | 8 | Page-buffer byte address |
| pb_wdata | output | 8 | Page-buffer byte data |
| pb_commit | output | 1 | Start programming, one cycle on STOP |

## Verification
The hardest case to reach is the pointer crossing from 255 to 0 in the middle of a read stream, combined with the master's acknowledge deciding whether a byte follows. The bench first aims the pointer at 254 with a write cut short by a repeated START. It then clocks four bytes with three acknowledges and a final refusal. Aborts in the middle of a byte come from START and STOP events placed after only a few data clocks, in a control byte, a write data byte and a read byte.

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          sda_in,
  input  logic          wr_busy,
  output logic          sda_pull,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          pb_we,
  output logic [AW-1:0] pb_addr,
  output logic [7:0]    pb_wdata,
  output logic          pb_commit
);
  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WDATA, S_ACK, S_RDATA, S_RACK, S_IGN} st_t;

  st_t          st, nxt;
  logic [3:0]   cnt;
  logic [7:0]   sh, txsh;
  logic [AW-1:0] ptr;
  logic         ack_q, dirty;
  logic [7:0]   rx;

  assign rx       = {sh[6:0], sda_in};
  assign mem_addr = ptr;

  wire recv = (st == S_CTRL) || (st == S_ADDR) || (st == S_WDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; sh <= '0; txsh <= '0;
      ptr <= '0; ack_q <= 1'b0; dirty <= 1'b0; sda_pull <= 1'b0;
      pb_we <= 1'b0; pb_addr <= '0; pb_wdata <= '0; pb_commit <= 1'b0;
    end else begin
      pb_we <= 1'b0;
      pb_commit <= 1'b0;
      if (ev_start) begin
        st <= S_CTRL; cnt <= '0; sda_pull <= 1'b0; dirty <= 1'b0;
      end else if (ev_stop) begin
        st <= S_IDLE; cnt <= '0; sda_pull <= 1'b0;
        pb_commit <= dirty; dirty <= 1'b0;
      end else if (ev_rise) begin
        if (recv && cnt < 4'd8) begin
          sh <= rx;
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            case (st)
              S_CTRL: begin
                ack_q <= (rx[7:4] == DEV_CODE);
                nxt <= rx[0] ? S_RDATA : S_ADDR;
              end
              S_ADDR: begin
                ptr <= AW'(rx); ack_q <= 1'b1; nxt <= S_WDATA;
              end
              default: begin
                ack_q <= 1'b1; nxt <= S_WDATA;
                if (!wr_busy) begin
                  pb_we <= 1'b1; pb_addr <= ptr; pb_wdata <= rx;
                  ptr <= ptr + 1'b1; dirty <= 1'b1;
                end
              end
            endcase
          end
        end else if (st == S_ACK) begin
          cnt <= 4'd1;
        end else if (st == S_RDATA && cnt < 4'd8) begin
          cnt <= cnt + 4'd1;
        end else if (st == S_RACK) begin
          if (sda_in) st <= S_IGN;
          else cnt <= 4'd1;
        end
      end else if (ev_fall) begin
        if (recv && cnt == 4'd8) begin
          if (ack_q && !wr_busy) begin
            sda_pull <= 1'b1; st <= S_ACK; cnt <= '0;
          end else begin
            st <= S_IGN;
          end
        end else if ((st == S_ACK || st == S_RACK) && cnt == 4'd1) begin
          cnt <= '0;
          if (st == S_RACK || nxt == S_RDATA) begin
            st <= S_RDATA;
            txsh <= mem_rdata;
            sda_pull <= ~mem_rdata[7];
            ptr <= ptr + 1'b1;
          end else begin
            st <= nxt;
            sda_pull <= 1'b0;
          end
        end else if (st == S_RDATA) begin
          if (cnt == 4'd8) begin
            sda_pull <= 1'b0; st <= S_RACK; cnt <= '0;
          end else if (cnt != 4'd0) begin
            txsh <= {txsh[6:0], 1'b0};
            sda_pull <= ~txsh[6];
          end
        end
      end
    end
  end

  AST_LINE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_fall && !ev_start && !ev_stop) |=> $stable(sda_pull)); // R8
  AST_RELEASE_ON_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_stop) |=> !sda_pull); // R11
  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && st == S_ACK) |-> !$past(wr_busy)); // R3
  AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we |-> (mem_addr == pb_addr + 1'b1)); // R4
  AST_COMMIT_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    pb_commit |-> (st == S_IDLE && !sda_pull)); // R5
  AST_IGNORED_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> (!sda_pull && !pb_we)); // R2
endmodule

// File: tb/serial_mem_slave_test.sv
module serial_mem_slave_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_rise = 0, ev_fall = 0, wr_busy = 0, m_sda = 1;
  logic sda_in, sda_pull, pb_we, pb_commit;
  logic [7:0] mem_addr, mem_rdata, pb_addr, pb_wdata;
  int checks = 0, errors = 0, nw = 0, ncommit = 0;
  logic [7:0] wa [16];
  logic [7:0] wd [16];
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_in = m_sda & ~sda_pull;

  serial_mem_slave uut (.clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .sda_in(sda_in), .wr_busy(wr_busy),
    .sda_pull(sda_pull), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pb_we(pb_we),
    .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_commit(pb_commit));

  function automatic logic [7:0] f(input logic [7:0] a);
    return (a * 8'd37) ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) mem_rdata <= f(mem_addr);

  always @(posedge clk) begin
    if (pb_we) begin
      wa[nw[3:0]] <= pb_addr; wd[nw[3:0]] <= pb_wdata; nw <= nw + 1;
    end
    if (pb_commit) ncommit <= ncommit + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cond(input bit is_start);
    @(negedge clk);
    if (is_start) ev_start = 1; else ev_stop = 1;
    @(negedge clk); ev_start = 0; ev_stop = 0;
    @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    @(negedge clk); m_sda = b; ev_rise = 1;
    @(negedge clk); ev_rise = 0;
    @(negedge clk); s = sda_in;
    @(negedge clk); ev_fall = 1;
    @(negedge clk); ev_fall = 0;
    @(negedge clk); m_sda = 1;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] v, output logic rel);
    logic s;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, s); v = {v[6:0], s}; end
    rel = !sda_pull;
    clk_bit(!mack, s);
  endtask

  task automatic set_ptr(input logic [7:0] a, output logic ok);
    logic k1, k2;
    cond(1); send_byte(8'hA0, k1); send_byte(a, k2);
    ok = k1 && k2;
  endtask

  localparam logic [7:0] TAB_A [6] = '{8'h00, 8'h5C, 8'h80, 8'hA7, 8'h3F, 8'hFF};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ok, ack, rel;
    logic [7:0] v;
    logic pulled;
    repeat (3) @(negedge clk);
    chk(!sda_pull && !pb_we && !pb_commit, "R8 reset released", sda_pull, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (TAB_A[i]) begin
      set_ptr(TAB_A[i], ok);
      chk(ok, "R1 R4 control and address ack", ok, 1);
      cond(1); send_byte(8'hA1, ack);
      chk(ack, "R1 read control ack", ack, 1);
      read_byte(1'b0, v, rel);
      chk(v == f(TAB_A[i]), "R6 random read data", v, f(TAB_A[i]));
      cond(0);
    end
    chk(ncommit == 0 && nw == 0, "R5 no commit without data", ncommit, 0);

    cond(1); send_byte(8'hA1, ack); read_byte(1'b0, v, rel); cond(0);
    chk(v == f(8'h00), "R9 pointer wrapped to 0", v, f(8'h00));

    cond(1); send_byte(8'hAE, ack); cond(0);
    chk(ack, "R1 ignored bits accepted", ack, 1);

    cond(1); send_byte(8'hB0, ack);
    chk(!ack, "R2 wrong code no ack", ack, 0);
    send_byte(8'hA0, ack);
    chk(!ack, "R2 ignored until START", ack, 0);
    cond(0);
    cond(1); send_byte(8'hA0, ack); cond(0);
    chk(ack, "R2 recovers after START", ack, 1);

    wr_busy = 1;
    cond(1); send_byte(8'hA0, ack); cond(0);
    chk(!ack, "R3 busy write control", ack, 0);
    cond(1); send_byte(8'hA1, ack); cond(0);
    chk(!ack, "R3 busy read control", ack, 0);
    wr_busy = 0;

    set_ptr(8'h10, ok);
    send_byte(8'h11, ack); chk(ack, "R4 data ack", ack, 1);
    send_byte(8'h22, ack); chk(ack, "R4 data ack", ack, 1);
    send_byte(8'h33, ack); chk(ack, "R4 data ack", ack, 1);
    cond(0);
    @(negedge clk);
    chk(nw == 3, "R4 write strobes", nw, 3);
    chk(wa[0] == 8'h10 && wa[1] == 8'h11 && wa[2] == 8'h12, "R4 write addresses", wa[2], 8'h12);
    chk(wd[0] == 8'h11 && wd[1] == 8'h22 && wd[2] == 8'h33, "R4 write data", wd[2], 8'h33);
    chk(ncommit == 1, "R5 commit on STOP", ncommit, 1);

    cond(1); send_byte(8'hA1, ack); read_byte(1'b0, v, rel); cond(0);
    chk(v == f(8'h13), "R7 current address read", v, f(8'h13));

    set_ptr(8'hFE, ok);
    cond(1); send_byte(8'hA1, ack);
    read_byte(1'b1, v, rel);
    chk(v == f(8'hFE) && rel, "R8 first byte and released slot", v, f(8'hFE));
    read_byte(1'b1, v, rel);
    chk(v == f(8'hFF) && rel, "R9 sequential byte", v, f(8'hFF));
    read_byte(1'b1, v, rel);
    chk(v == f(8'h00), "R9 wrap 255 to 0", v, f(8'h00));
    read_byte(1'b0, v, rel);
    chk(v == f(8'h01), "R9 last byte", v, f(8'h01));

    pulled = 0;
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, ok);
      if (!ok) pulled = 1;
    end
    chk(!pulled, "R10 silent after refusal", pulled, 0);
    send_byte(8'hA1, ack);
    chk(!ack, "R10 no ack without START", ack, 0);
    cond(0);
    cond(1); send_byte(8'hA1, ack); read_byte(1'b0, v, rel); cond(0);
    chk(v == f(8'h02), "R7 pointer after refused read", v, f(8'h02));

    cond(1);
    clk_bit(1, ok); clk_bit(0, ok); clk_bit(1, ok); clk_bit(0, ok);
    cond(1); send_byte(8'hA1, ack);
    chk(ack, "R11 control after mid-byte START", ack, 1);
    read_byte(1'b0, v, rel); cond(0);
    chk(v == f(8'h03), "R11 read after abort", v, f(8'h03));

    set_ptr(8'h40, ok);
    clk_bit(1, ok); clk_bit(1, ok); clk_bit(0, ok); clk_bit(1, ok);
    cond(1); cond(0);
    @(negedge clk);
    chk(nw == 3 && ncommit == 1, "R11 partial data not written", nw, 3);
    cond(1); send_byte(8'hA1, ack); read_byte(1'b0, v, rel); cond(0);
    chk(v == f(8'h40), "R6 pointer kept after cut write", v, f(8'h40));

    cond(1); send_byte(8'hA1, ack);
    clk_bit(1, ok); clk_bit(1, ok); clk_bit(1, ok);
    cond(0);
    chk(!sda_pull, "R11 STOP mid-read releases", sda_pull, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule